// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds three outgoing CAN frames, one per mailbox, and decides which of them goes to the transmitter next. The host loads a mailbox with an identifier, and that makes it pending. Whenever no mailbox is on the wire, the scheduler picks one pending mailbox and hands it to a simple transmitter handshake. The transmitter answers with either a completion (the frame went out and was acknowledged) or a lost-arbitration result. A mode input selects the ordering. With the mode clear, the lowest identifier wins, because a lower identifier carries higher priority. With the mode set, mailboxes go out in the order the host requested them.

While a mailbox is on the wire it is locked, so host writes to it are dropped. An abort request empties a waiting mailbox at once. On a mailbox that is on the wire, the abort only takes effect if the attempt is lost. A 2-bit code tells the host which mailbox to use next. It names a free mailbox if there is one. When all three are occupied, it names the pending frame with the lowest priority, which is the one a driver would pull back to make room for a more urgent frame.

Top module: `can_tx_mbox_sched`

## Requirements
- R1: After synchronous reset every mailbox is empty, `tx_start` is low and `free_code` is 0.
- R2: A write (`wr_en`, `wr_idx`, `wr_id`) to a mailbox that is not transmitting stores the identifier and makes the mailbox pending on the next cycle. A write to the transmitting mailbox is ignored: the mailbox keeps its frame and its place in request order.
- R3: With `mode_fifo`=0, if no mailbox is transmitting at a clock edge and some mailbox is eligible, `tx_start` is high for the following cycle. `tx_idx`/`tx_id` then name the eligible mailbox with the numerically lowest identifier, ties going to the lower index, and that mailbox shows as transmitting. A pending mailbox is eligible unless it is written or aborted in that same cycle.
- R4: With `mode_fifo`=1 the eligible mailbox whose accepted write is oldest is started. At reset the request order is mailbox 0, 1, 2.
- R5: `tx_done` while a mailbox transmits moves it to done-ok and raises its `ok_pulse` bit for exactly one cycle. `tx_done` or `tx_lost` with no mailbox transmitting has no effect.
- R6: `tx_lost` (with `tx_done` low) returns the transmitting mailbox to pending, and it takes part in selection again at the next idle edge.
- R7: An abort request on a pending mailbox moves it to aborted, even in the very cycle it would have been selected; then no start occurs for it. An abort request on an empty, done-ok or aborted mailbox has no effect.
- R8: An abort request on the transmitting mailbox is remembered. If the attempt then ends with `tx_lost`, the mailbox becomes aborted. If it ends with `tx_done`, the mailbox becomes done-ok and pulses `ok_pulse`.
- R9: `free_code` gives the lowest index of a mailbox that is empty, done-ok or aborted. When none is free, it gives the pending mailbox with the numerically highest identifier, ties going to the higher index.
- R10: At most one mailbox is transmitting, and no new start is issued while one is.
- R11: Each mailbox shows exactly one of the five flags empty, pending, transmitting, done-ok, aborted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_fifo | input | 1 | 0: identifier priority, 1: request order |
| wr_en | input | 1 | Load a mailbox and request transmission |
| wr_idx | input | 2 | Mailbox to load |
| wr_id | input | ID_W | Frame identifier to load |
| abort_req | input | NUM_MB | Per-mailbox abort request |
| tx_done | input | 1 | Transmitter: frame sent and acknowledged |
| tx_lost | input | 1 | Transmitter: arbitration lost |
| tx_start | output | 1 | One-cycle start to the transmitter |
| tx_idx | output | 2 | Mailbox being started |
| tx_id | output | ID_W | Identifier being started |
| mb_empty | output | NUM_MB | Mailbox empty |
| mb_pend | output | NUM_MB | Mailbox pending |
| mb_xmit | output | NUM_MB | Mailbox on the wire |
| mb_ok | output | NUM_MB | Mailbox finished with acknowledge |
| mb_abrt | output | NUM_MB | Mailbox aborted |
| ok_pulse | output | NUM_MB | One-cycle completion per mailbox |
| free_code | output | 2 | Next free mailbox or lowest-priority pending one |

## Verification
The interesting collision is an abort that lands on the same edge where the scheduler would otherwise start that mailbox. A second one is an abort that lands while the mailbox is on the wire, together with or ahead of the transmitter's verdict. The bench provokes the first case on purpose: it loads a mailbox while the bus is idle, then aborts it on the very next edge. It provokes the second by aborting during a transmission and then ending it once with a loss and once with a completion. A long stretch of random writes, aborts and transmitter responses then creates many more of these coincidences. A behavioural model, which keeps request order in a queue, judges every cycle by comparing all flags, the start and its payload, the completion pulses and the free code.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  typedef enum logic [2:0] {
    MB_EMPTY = 3'd0,
    MB_PEND  = 3'd1,
    MB_XMIT  = 3'd2,
    MB_OK    = 3'd3,
    MB_ABRT  = 3'd4
  } mb_state_e;
endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
#(
  parameter int ID_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [ID_W-1:0] wr_id,
  input  logic            abort,
  input  logic            launch,
  input  logic            done,
  input  logic            lost,
  output mb_state_e       state,
  output logic [ID_W-1:0] id,
  output logic            ok_pulse
);
  logic abort_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= MB_EMPTY;
      id         <= '0;
      abort_held <= 1'b0;
      ok_pulse   <= 1'b0;
    end else begin
      ok_pulse <= 1'b0;
      if (state == MB_XMIT) begin
        if (done) begin
          state      <= MB_OK;
          ok_pulse   <= 1'b1;
          abort_held <= 1'b0;
        end else if (lost) begin
          state      <= (abort_held || abort) ? MB_ABRT : MB_PEND;
          abort_held <= 1'b0;
        end else if (abort) begin
          abort_held <= 1'b1;
        end
      end else if (wr) begin
        state <= MB_PEND;
        id    <= wr_id;
      end else if (launch) begin
        state <= MB_XMIT;
      end else if (abort && state == MB_PEND) begin
        state <= MB_ABRT;
      end
    end
  end

  // R2: frame is frozen while on the wire
  p_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (state == MB_XMIT && !done && !lost) |=> (state == MB_XMIT && $stable(id)));

  // R3: launch only reaches an eligible pending mailbox
  p_launch_pending_r3: assert property (@(posedge clk) disable iff (rst)
    launch |-> (state == MB_PEND && !wr && !abort));

  // R5: completion only follows an acknowledged transmission
  p_ok_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    ok_pulse |-> $past(state == MB_XMIT && done));

  // R7: abort of a waiting mailbox empties it
  p_abort_pend_r7: assert property (@(posedge clk) disable iff (rst)
    (abort && !wr && state == MB_PEND) |=> (state == MB_ABRT));
endmodule

// File: rtl/can_txmb_age.sv
module can_txmb_age #(
  parameter int NUM_MB = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [$clog2(NUM_MB)-1:0] wr_idx,
  output logic [NUM_MB*NUM_MB-1:0]  older
);
  // older[i*NUM_MB+j] = 1 : mailbox i was requested before mailbox j
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MB; i++)
        for (int j = 0; j < NUM_MB; j++)
          older[i*NUM_MB+j] <= (i < j);
    end else if (wr) begin
      for (int j = 0; j < NUM_MB; j++) begin
        if (j != int'(wr_idx)) begin
          older[int'(wr_idx)*NUM_MB+j] <= 1'b0;
          older[j*NUM_MB+int'(wr_idx)] <= 1'b1;
        end
      end
    end
  end

  // R4: request order stays a strict total order
  for (genvar a = 0; a < NUM_MB; a++) begin : g_a
    for (genvar b = a + 1; b < NUM_MB; b++) begin : g_b
      p_age_antisym_r4: assert property (@(posedge clk) disable iff (rst)
        older[a*NUM_MB+b] != older[b*NUM_MB+a]);
    end
  end
endmodule

// File: rtl/can_txmb_pick.sv
module can_txmb_pick #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11
) (
  input  logic                      mode_fifo,
  input  logic [NUM_MB-1:0]         elig,
  input  logic [NUM_MB-1:0]         pend,
  input  logic [NUM_MB-1:0]         free,
  input  logic [ID_W-1:0]           ids [NUM_MB],
  input  logic [NUM_MB*NUM_MB-1:0]  older,
  output logic                      sel_valid,
  output logic [$clog2(NUM_MB)-1:0] sel_idx,
  output logic [$clog2(NUM_MB)-1:0] code
);
  localparam int IDX_W = $clog2(NUM_MB);

  logic             p_valid, f_valid, blocked, found, w_valid;
  logic [IDX_W-1:0] p_idx, f_idx;
  logic [ID_W-1:0]  best_id, worst_id;

  always_comb begin
    p_valid = 1'b0;
    p_idx   = '0;
    best_id = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (elig[i] && (!p_valid || ids[i] < best_id)) begin
        p_valid = 1'b1;
        p_idx   = IDX_W'(i);
        best_id = ids[i];
      end
    end

    f_valid = 1'b0;
    f_idx   = '0;
    blocked = 1'b0;
    for (int i = 0; i < NUM_MB; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < NUM_MB; j++)
        if (j != i && elig[j] && older[j*NUM_MB+i]) blocked = 1'b1;
      if (elig[i] && !blocked && !f_valid) begin
        f_valid = 1'b1;
        f_idx   = IDX_W'(i);
      end
    end

    sel_valid = mode_fifo ? f_valid : p_valid;
    sel_idx   = mode_fifo ? f_idx : p_idx;

    code     = '0;
    found    = 1'b0;
    w_valid  = 1'b0;
    worst_id = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (free[i] && !found) begin
        found = 1'b1;
        code  = IDX_W'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (pend[i] && (!w_valid || ids[i] >= worst_id)) begin
          w_valid  = 1'b1;
          worst_id = ids[i];
          code     = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/can_tx_mbox_sched.sv
module can_tx_mbox_sched
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode_fifo,
  input  logic                      wr_en,
  input  logic [$clog2(NUM_MB)-1:0] wr_idx,
  input  logic [ID_W-1:0]           wr_id,
  input  logic [NUM_MB-1:0]         abort_req,
  input  logic                      tx_done,
  input  logic                      tx_lost,
  output logic                      tx_start,
  output logic [$clog2(NUM_MB)-1:0] tx_idx,
  output logic [ID_W-1:0]           tx_id,
  output logic [NUM_MB-1:0]         mb_empty,
  output logic [NUM_MB-1:0]         mb_pend,
  output logic [NUM_MB-1:0]         mb_xmit,
  output logic [NUM_MB-1:0]         mb_ok,
  output logic [NUM_MB-1:0]         mb_abrt,
  output logic [NUM_MB-1:0]         ok_pulse,
  output logic [$clog2(NUM_MB)-1:0] free_code
);
  localparam int IDX_W = $clog2(NUM_MB);

  mb_state_e               st  [NUM_MB];
  logic [ID_W-1:0]         ids [NUM_MB];
  logic [NUM_MB-1:0]       wr_hit, elig, launch, free;
  logic [NUM_MB*NUM_MB-1:0] older;
  logic                    idle, sel_valid, wr_acc;
  logic [IDX_W-1:0]        sel_idx;

  assign idle   = (mb_xmit == '0);
  assign wr_acc = wr_en && !mb_xmit[wr_idx];

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    assign wr_hit[g] = wr_en && (wr_idx == IDX_W'(g));
    assign elig[g]   = mb_pend[g] && !wr_hit[g] && !abort_req[g];
    assign launch[g] = idle && sel_valid && (sel_idx == IDX_W'(g));

    can_txmb_slot #(.ID_W(ID_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_hit[g]),
      .wr_id    (wr_id),
      .abort    (abort_req[g]),
      .launch   (launch[g]),
      .done     (tx_done),
      .lost     (tx_lost),
      .state    (st[g]),
      .id       (ids[g]),
      .ok_pulse (ok_pulse[g])
    );

    assign mb_empty[g] = (st[g] == MB_EMPTY);
    assign mb_pend[g]  = (st[g] == MB_PEND);
    assign mb_xmit[g]  = (st[g] == MB_XMIT);
    assign mb_ok[g]    = (st[g] == MB_OK);
    assign mb_abrt[g]  = (st[g] == MB_ABRT);
    assign free[g]     = mb_empty[g] | mb_ok[g] | mb_abrt[g];
  end

  can_txmb_age #(.NUM_MB(NUM_MB)) u_age (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_acc),
    .wr_idx (wr_idx),
    .older  (older)
  );

  can_txmb_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_pick (
    .mode_fifo (mode_fifo),
    .elig      (elig),
    .pend      (mb_pend),
    .free      (free),
    .ids       (ids),
    .older     (older),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .code      (free_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start <= 1'b0;
      tx_idx   <= '0;
      tx_id    <= '0;
    end else begin
      tx_start <= idle && sel_valid;
      if (idle && sel_valid) begin
        tx_idx <= sel_idx;
        tx_id  <= ids[sel_idx];
      end
    end
  end

  // R10: a single mailbox on the wire at any time
  p_single_xmit_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mb_xmit));

  // R10: a start only follows an idle edge
  p_start_after_idle_r10: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(mb_xmit == '0));

  // R3: the started mailbox is the one now locked
  p_start_locks_r3: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> mb_xmit[tx_idx]);

  // R9: a free mailbox is always preferred by the code
  p_code_free_r9: assert property (@(posedge clk) disable iff (rst)
    (free != '0) |-> free[free_code]);
endmodule

// File: tb/tb_can_tx_mbox_sched.sv
module tb_can_tx_mbox_sched;
  localparam int N = 3;
  localparam int IW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_fifo = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [IW-1:0] wr_id = '0;
  logic [N-1:0] abort_req = '0;
  logic tx_done = 1'b0, tx_lost = 1'b0;
  logic tx_start;
  logic [1:0] tx_idx, free_code;
  logic [IW-1:0] tx_id;
  logic [N-1:0] mb_empty, mb_pend, mb_xmit, mb_ok, mb_abrt, ok_pulse;

  always #5 clk = ~clk;

  can_tx_mbox_sched #(.NUM_MB(N), .ID_W(IW)) dut (
    .clk(clk), .rst(rst), .mode_fifo(mode_fifo), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_id(wr_id), .abort_req(abort_req), .tx_done(tx_done), .tx_lost(tx_lost),
    .tx_start(tx_start), .tx_idx(tx_idx), .tx_id(tx_id), .mb_empty(mb_empty),
    .mb_pend(mb_pend), .mb_xmit(mb_xmit), .mb_ok(mb_ok), .mb_abrt(mb_abrt),
    .ok_pulse(ok_pulse), .free_code(free_code));

  int total = 0, bad = 0;
  bit finished = 0;

  // model: 0 empty, 1 pending, 2 transmitting, 3 done-ok, 4 aborted
  int m_st[N];
  int m_id[N];
  bit m_abl[N];
  int m_q[$];
  bit m_start;
  int m_tidx, m_tid;
  bit [N-1:0] m_okp;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_id[i] = 0; m_abl[i] = 0; end
    m_q = {0, 1, 2};
    m_start = 0; m_tidx = 0; m_tid = 0; m_okp = '0;
  endfunction

  function automatic void model_update();
    bit any_x = 0;
    bit el[N];
    int pick = -1;
    for (int i = 0; i < N; i++) if (m_st[i] == 2) any_x = 1;
    for (int i = 0; i < N; i++)
      el[i] = (m_st[i] == 1) && !(wr_en && int'(wr_idx) == i) && !abort_req[i];
    if (!any_x) begin
      if (!mode_fifo) begin
        for (int i = 0; i < N; i++)
          if (el[i] && (pick < 0 || m_id[i] < m_id[pick])) pick = i;
      end else begin
        foreach (m_q[k]) if (pick < 0 && el[m_q[k]]) pick = m_q[k];
      end
    end
    m_okp = '0;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] == 2) begin
        if (tx_done) begin m_st[i] = 3; m_okp[i] = 1; m_abl[i] = 0; end
        else if (tx_lost) begin m_st[i] = (m_abl[i] || abort_req[i]) ? 4 : 1; m_abl[i] = 0; end
        else if (abort_req[i]) m_abl[i] = 1;
      end else if (wr_en && int'(wr_idx) == i) begin
        m_st[i] = 1; m_id[i] = int'(wr_id);
        foreach (m_q[k]) if (m_q[k] == i) begin m_q.delete(k); break; end
        m_q.push_back(i);
      end else if (pick == i) begin
        m_st[i] = 2;
      end else if (abort_req[i] && m_st[i] == 1) begin
        m_st[i] = 4;
      end
    end
    m_start = (pick >= 0);
    if (m_start) begin m_tidx = pick; m_tid = m_id[pick]; end
  endfunction

  function automatic int model_code();
    int c = -1;
    for (int i = 0; i < N; i++) if (c < 0 && (m_st[i] == 0 || m_st[i] >= 3)) c = i;
    if (c >= 0) return c;
    for (int i = 0; i < N; i++) if (m_st[i] == 1 && (c < 0 || m_id[i] >= m_id[c])) c = i;
    return (c < 0) ? 0 : c;
  endfunction

  task automatic compare();
    bit [N-1:0] e0, e1, e2, e3, e4;
    for (int i = 0; i < N; i++) begin
      e0[i] = m_st[i] == 0; e1[i] = m_st[i] == 1; e2[i] = m_st[i] == 2;
      e3[i] = m_st[i] == 3; e4[i] = m_st[i] == 4;
    end
    chk(mb_empty == e0, "R11 empty flags", mb_empty, e0);
    chk(mb_pend == e1, "R2 pending flags", mb_pend, e1);
    chk(mb_xmit == e2, "R10 transmitting flags", mb_xmit, e2);
    chk(mb_ok == e3, "R5 done-ok flags", mb_ok, e3);
    chk(mb_abrt == e4, "R7 aborted flags", mb_abrt, e4);
    chk(ok_pulse == m_okp, "R5 ok_pulse", ok_pulse, m_okp);
    chk(tx_start == m_start, "R3 tx_start", tx_start, m_start);
    if (m_start) begin
      chk(int'(tx_idx) == m_tidx, "R3 tx_idx", tx_idx, m_tidx);
      chk(int'(tx_id) == m_tid, "R3 tx_id", tx_id, m_tid);
    end
    chk(int'(free_code) == model_code(), "R9 free_code", free_code, model_code());
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_update();
    @(negedge clk);
    compare();
    wr_en = 0; abort_req = '0; tx_done = 0; tx_lost = 0;
  endtask

  task automatic wr(int idx, int id);
    wr_en = 1; wr_idx = 2'(idx); wr_id = IW'(id);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) tick();
    rst = 0;
    tick();
    chk(mb_empty == 3'b111 && free_code == 0 && !tx_start, "R1 reset state", mb_empty, 3'b111);

    wr(0, 'h7FF); tick();
    chk(mb_pend[0], "R2 write makes pending", mb_pend, 3'b001);
    tick();
    chk(tx_start && tx_idx == 0, "R3 first start", tx_idx, 0);
    wr(1, 'h010); tick();
    wr(2, 'h010); tick();
    wr(0, 'h001); tick();
    chk(mb_xmit[0], "R2 locked mailbox keeps state", mb_xmit, 3'b001);
    chk(free_code == 2, "R9 all full names highest id, higher index", free_code, 2);
    tx_done = 1; tick();
    chk(mb_ok[0] && ok_pulse == 3'b001, "R5 completion", ok_pulse, 3'b001);
    tick();
    chk(tx_start && tx_idx == 1 && tx_id == 'h010, "R3 tie goes to lower index", tx_idx, 1);
    tx_lost = 1; tick();
    chk(mb_pend[1], "R6 lost returns to pending", mb_pend, 3'b110);
    tick();
    chk(tx_start && tx_idx == 1, "R6 reselected after loss", tx_idx, 1);
    abort_req = 3'b010; tick();
    tx_done = 1; tick();
    chk(mb_ok[1] && ok_pulse[1], "R8 done beats held abort", mb_ok, 3'b011);
    tick();
    chk(tx_start && tx_idx == 2, "R3 next start", tx_idx, 2);
    abort_req = 3'b100; tick();
    tx_lost = 1; tick();
    chk(mb_abrt[2], "R8 held abort applies on loss", mb_abrt, 3'b100);
    abort_req = 3'b001; tick();
    chk(mb_ok[0] && !mb_abrt[0], "R7 abort on done-ok ignored", mb_ok, 3'b011);

    mode_fifo = 1;
    wr(0, 'h100); tick();
    tick();
    wr(2, 'h050); tick();
    wr(1, 'h020); tick();
    tx_done = 1; tick();
    tick();
    chk(tx_start && tx_idx == 2, "R4 request order beats identifier", tx_idx, 2);
    tx_done = 1; tick();
    tick();
    chk(tx_start && tx_idx == 1, "R4 second in request order", tx_idx, 1);
    tx_done = 1; tick();
    wr(0, 'h200); tick();
    abort_req = 3'b001; tick();
    chk(!tx_start && mb_abrt[0], "R7 abort wins over selection", tx_start, 0);
    tx_done = 1; tick();
    chk(ok_pulse == 0, "R5 done with nothing on the wire ignored", ok_pulse, 0);

    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) mode_fifo = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 2) == 0) wr(int'($urandom_range(0, 2)), int'($urandom_range(0, 5)) * 'h40);
      if ($urandom_range(0, 9) == 0) abort_req = 3'($urandom_range(1, 7));
      case ($urandom_range(0, 7))
        0: tx_done = 1;
        1: tx_lost = 1;
        default: ;
      endcase
      tick();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule